// File: doc/BRIEF.md
# Dual-Buffer Sequential Address Pointer

This block generates the word address for the clocked side of a 4096 x 16 shared memory. It holds a 12-bit pointer. Each clock edge moves the pointer in one of four ways: it steps forward by one, it takes a value captured from the sequential data bus one cycle earlier, it jumps to one of two programmable buffer start addresses, or it holds. Two comparators watch the pointer as it steps forward. When a step lands on the end address of a buffer, that buffer's active-low end-of-buffer flag goes low and stays low until it is cleared.

A host on the random-access side programs the two start/end pairs and clears the flags through a small register file. It selects that register file with its command select and a 3-bit register address. The block also registers the write and read cycle qualifiers, together with the access address and write data, that go to the memory array. The array, the pads and power-down are outside the block.

Top module: `seqbuf_ptr`

## Requirements
- R1: An active-low `rst_n` acts at once, with no clock edge needed. It sets the pointer to 0, drives `eob1_n` and `eob2_n` high, clears all host registers to 0, and drives `mem_wr`, `mem_rd` and `proto_err` low.
- R2: On a rising edge where `cnt_en_n` is low and no higher-priority action occurs, the pointer advances by one. From 4095 it wraps to 0.
- R3: On an edge where `ld_n` is sampled low, `sdata[11:0]` is captured and the pointer holds. The pointer takes the captured value on the next edge.
- R4: On an edge where `strt1_n` or `strt2_n` is low, the pointer is loaded from start register 1 or start register 2. If both strobes are low, start register 1 wins.
- R5: The priority order is fixed: a pending delayed load comes first, then a capture edge (`ld_n` low), then the start strobes, then the increment.
- R6: A flag goes low only on the edge where an increment lands the pointer on that buffer's end address. A strobe or load that lands on the end address leaves the flag unchanged. Once low, the flag stays low until it is cleared.
- R7: A host write to register address 5 (binary 101) clears flag 1 when data bit 0 is 0, and clears flag 2 when data bit 1 is 0. A 1 in either bit leaves that flag unchanged.
- R8: The host registers are selected only while `hcmd_n` is low and `hce_n` is high. `hrw` high means read and low means write. The register addresses are: 0 start 1, 1 end 1, 2 start 2, 3 end 2, all 12 bits wide. Address 4 is status, with bit 0 set while flag 1 is low and bit 1 set while flag 2 is low; writes to it are ignored. Addresses 5, 6 and 7 read as 0. Reads are combinational and give 0 when the registers are not selected. A write takes effect on the next rising edge.
- R9: `proto_err` is high for the one cycle after an edge where a start strobe was low while `ld_n` was low or a delayed load was pending. Otherwise it is low.
- R10: After each edge, `mem_wr` is high exactly when `sce_n` and `srw` were both low at that edge. `mem_rd` is high exactly when `srw` was high and both `sce_n` and `soe_n` were low. `acc_addr` shows the pointer value as it stood before that edge, and `acc_wdata` shows the `sdata` value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequential-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_n | input | 1 | Active-low increment enable |
| ld_n | input | 1 | Active-low direct pointer load |
| strt1_n | input | 1 | Active-low jump to buffer 1 start |
| strt2_n | input | 1 | Active-low jump to buffer 2 start |
| sce_n | input | 1 | Active-low sequential chip enable |
| srw | input | 1 | Sequential read (1) / write (0) |
| soe_n | input | 1 | Active-low sequential output enable |
| sdata | input | 16 | Sequential data bus |
| hcmd_n | input | 1 | Active-low host register select |
| hce_n | input | 1 | Host memory enable (must be high for register access) |
| hrw | input | 1 | Host read (1) / write (0) |
| haddr | input | 3 | Host register address |
| hwdata | input | 12 | Host write data |
| hrdata | output | 12 | Host read data |
| ptr | output | 12 | Current pointer |
| eob1_n | output | 1 | Active-low sticky end-of-buffer flag 1 |
| eob2_n | output | 1 | Active-low sticky end-of-buffer flag 2 |
| proto_err | output | 1 | Strobe inside the forbidden load window |
| mem_wr | output | 1 | Registered array write qualifier |
| mem_rd | output | 1 | Registered array read qualifier |
| acc_addr | output | 12 | Array address for the qualified cycle |
| acc_wdata | output | 16 | Array write data for the qualified cycle |

## Verification
The hardest case to reach is the second cycle of the load window. In that cycle a strobe arrives while the delayed load is pending but `ld_n` is already high again, so nothing on the inputs shows that the strobe is forbidden. The bench asserts `ld_n` together with a strobe for one edge, then keeps the strobe low for the following edge. It then checks that the pointer takes the captured value rather than the start address, and that `proto_err` is high after both edges. A second hard case is the wrap from 4095 to 0 followed by a match on a small end address. The bench reaches it by jumping to a start address near the top of the memory and counting through the wrap.

// File: rtl/seqbuf_pkg.sv
package seqbuf_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 16;
  localparam int NBUF    = 2;
  localparam int HADDR_W = 3;

  localparam logic [HADDR_W-1:0] REG_STATUS = 3'd4;
  localparam logic [HADDR_W-1:0] REG_CTRL   = 3'd5;

  // next pointer on an increment: natural wrap at the address width
  function automatic logic [ADDR_W-1:0] ptr_inc(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  // register slot of start/end of buffer i
  function automatic logic [HADDR_W-1:0] start_slot(input int i);
    return HADDR_W'(2 * i);
  endfunction

  function automatic logic [HADDR_W-1:0] end_slot(input int i);
    return HADDR_W'(2 * i + 1);
  endfunction
endpackage

// File: rtl/seqbuf_regfile.sv
module seqbuf_regfile
  import seqbuf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NB = NBUF,
  parameter int HA = HADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hcmd_n,
  input  logic                   hce_n,
  input  logic                   hrw,
  input  logic [HA-1:0]          haddr,
  input  logic [AW-1:0]          hwdata,
  input  logic [NB-1:0]          flags,
  output logic [NB-1:0][AW-1:0]  start_q,
  output logic [NB-1:0][AW-1:0]  end_q,
  output logic [NB-1:0]          flag_clr,
  output logic [AW-1:0]          hrdata
);
  logic host_sel, host_wr, host_rd;
  assign host_sel = !hcmd_n && hce_n;
  assign host_wr  = host_sel && !hrw;
  assign host_rd  = host_sel && hrw;

  for (genvar i = 0; i < NB; i++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[i] <= '0;
        end_q[i]   <= '0;
      end else if (host_wr) begin
        if (haddr == start_slot(i)) start_q[i] <= hwdata;
        if (haddr == end_slot(i))   end_q[i]   <= hwdata;
      end
    end
    assign flag_clr[i] = host_wr && (haddr == REG_CTRL) && !hwdata[i];
  end

  always_comb begin
    hrdata = '0;
    if (host_rd) begin
      for (int i = 0; i < NB; i++) begin
        if (haddr == start_slot(i)) hrdata = start_q[i];
        if (haddr == end_slot(i))   hrdata = end_q[i];
      end
      if (haddr == REG_STATUS) hrdata[NB-1:0] = flags;
    end
  end

  assert_status_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && haddr == REG_STATUS) |=> ($stable(start_q) && $stable(end_q)));
  assert_unselected_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel) |-> (hrdata == '0));
endmodule

// File: rtl/seqbuf_ptr_core.sv
module seqbuf_ptr_core
  import seqbuf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NB = NBUF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_en_n,
  input  logic                   ld_n,
  input  logic [NB-1:0]          strt_n,
  input  logic [AW-1:0]          ld_data,
  input  logic [NB-1:0][AW-1:0]  start_q,
  output logic [AW-1:0]          ptr_q,
  output logic                   inc_fire,
  output logic                   proto_err
);
  logic [AW-1:0] din_q;
  logic          ld_pend;
  logic          strb_any;
  logic [AW-1:0] strb_addr;
  logic          ld_fire, cap_now, strb_fire, viol;

  // lowest-numbered strobe wins
  always_comb begin
    strb_any  = 1'b0;
    strb_addr = '0;
    for (int i = 0; i < NB; i++) begin
      if (!strt_n[i] && !strb_any) begin
        strb_any  = 1'b1;
        strb_addr = start_q[i];
      end
    end
  end

  assign ld_fire   = ld_pend;
  assign cap_now   = !ld_n;
  assign strb_fire = !ld_fire && !cap_now && strb_any;
  assign inc_fire  = !ld_fire && !cap_now && !strb_any && !cnt_en_n;
  assign viol      = strb_any && (cap_now || ld_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q   <= '0;
      ld_pend <= 1'b0;
    end else begin
      ld_pend <= cap_now;
      if (cap_now) din_q <= ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (ld_fire)   ptr_q <= din_q;
    else if (strb_fire) ptr_q <= strb_addr;
    else if (inc_fire)  ptr_q <= ptr_inc(ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= viol;
  end

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inc_fire |=> (ptr_q == ptr_inc($past(ptr_q))));
  assert_capture_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_now && !ld_pend) |=> $stable(ptr_q));
  assert_delayed_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |=> (ptr_q == $past(din_q)));
  assert_load_beats_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pend && strb_any) |=> (ptr_q == $past(din_q)));
  assert_window_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_any && ld_pend) |=> proto_err);
endmodule

// File: rtl/seqbuf_eob.sv
module seqbuf_eob
  import seqbuf_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_fire,
  input  logic [AW-1:0] ptr_q,
  input  logic [AW-1:0] end_q,
  input  logic          clr,
  output logic          flag_q,
  output logic          eob_n
);
  logic hit;
  assign hit = inc_fire && (ptr_inc(ptr_q) == end_q);

  // a new hit wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign eob_n = ~flag_q;

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  assert_set_by_inc_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(inc_fire));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc_fire) |=> !flag_q);
endmodule

// File: rtl/seqbuf_qual.sv
module seqbuf_qual
  import seqbuf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sce_n,
  input  logic          srw,
  input  logic          soe_n,
  input  logic [AW-1:0] ptr_q,
  input  logic [DW-1:0] sdata,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata
);
  logic wr_req, rd_req;
  assign wr_req = !sce_n && !srw;
  assign rd_req = !sce_n && srw && !soe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wr    <= 1'b0;
      mem_rd    <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
    end else begin
      mem_wr    <= wr_req;
      mem_rd    <= rd_req;
      acc_addr  <= ptr_q;
      acc_wdata <= sdata;
    end
  end

  assert_write_qual_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sce_n && !srw) |=> mem_wr);
  assert_write_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sce_n || srw) |=> !mem_wr);
  assert_read_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

// File: rtl/seqbuf_ptr.sv
module seqbuf_ptr
  import seqbuf_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int HA = HADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en_n,
  input  logic          ld_n,
  input  logic          strt1_n,
  input  logic          strt2_n,
  input  logic          sce_n,
  input  logic          srw,
  input  logic          soe_n,
  input  logic [DW-1:0] sdata,
  input  logic          hcmd_n,
  input  logic          hce_n,
  input  logic          hrw,
  input  logic [HA-1:0] haddr,
  input  logic [AW-1:0] hwdata,
  output logic [AW-1:0] hrdata,
  output logic [AW-1:0] ptr,
  output logic          eob1_n,
  output logic          eob2_n,
  output logic          proto_err,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata
);
  localparam int NB = 2;

  logic [NB-1:0][AW-1:0] start_q, end_q;
  logic [NB-1:0]         flag_clr, flags, eob_vec;
  logic                  inc_fire;

  seqbuf_regfile #(.AW(AW), .NB(NB), .HA(HA)) u_regs (
    .clk, .rst_n, .hcmd_n, .hce_n, .hrw, .haddr, .hwdata,
    .flags, .start_q, .end_q, .flag_clr, .hrdata
  );

  seqbuf_ptr_core #(.AW(AW), .NB(NB)) u_core (
    .clk, .rst_n, .cnt_en_n, .ld_n,
    .strt_n   ({strt2_n, strt1_n}),
    .ld_data  (sdata[AW-1:0]),
    .start_q,
    .ptr_q    (ptr),
    .inc_fire,
    .proto_err
  );

  for (genvar i = 0; i < NB; i++) begin : g_eob
    seqbuf_eob #(.AW(AW)) u_eob (
      .clk, .rst_n, .inc_fire,
      .ptr_q  (ptr),
      .end_q  (end_q[i]),
      .clr    (flag_clr[i]),
      .flag_q (flags[i]),
      .eob_n  (eob_vec[i])
    );
  end

  assign eob1_n = eob_vec[0];
  assign eob2_n = eob_vec[1];

  seqbuf_qual #(.AW(AW), .DW(DW)) u_qual (
    .clk, .rst_n, .sce_n, .srw, .soe_n,
    .ptr_q (ptr),
    .sdata, .mem_wr, .mem_rd, .acc_addr, .acc_wdata
  );
endmodule

// File: tb/seqbuf_ptr_tb.sv
module seqbuf_ptr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en_n = 1'b1, ld_n = 1'b1, strt1_n = 1'b1, strt2_n = 1'b1;
  logic sce_n = 1'b1, srw = 1'b1, soe_n = 1'b1;
  logic [15:0] sdata = '0;
  logic hcmd_n = 1'b1, hce_n = 1'b1, hrw = 1'b1;
  logic [2:0]  haddr = '0;
  logic [11:0] hwdata = '0;
  logic [11:0] hrdata, ptr, acc_addr;
  logic [15:0] acc_wdata;
  logic eob1_n, eob2_n, proto_err, mem_wr, mem_rd;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seqbuf_ptr u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [11:0] d);
    hcmd_n = 0; hce_n = 1; hrw = 0; haddr = a; hwdata = d;
    tick();
    hcmd_n = 1; hrw = 1;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [11:0] d);
    hcmd_n = 0; hce_n = 1; hrw = 1; haddr = a;
    #1 d = hrdata;
    hcmd_n = 1;
  endtask

  task automatic count(input int n);
    cnt_en_n = 0;
    repeat (n) tick();
    cnt_en_n = 1;
  endtask

  task automatic t_reset();
    logic [11:0] d;
    chk("R1 ptr", ptr, 0);
    chk("R1 eob1", eob1_n, 1);
    chk("R1 eob2", eob2_n, 1);
    chk("R1 wr/rd/err", {mem_wr, mem_rd, proto_err}, 0);
    @(negedge clk); rst_n = 1; tick();
    host_rd(3'd2, d); chk("R1 start2 reg", d, 0);
  endtask

  task automatic t_regs();
    logic [11:0] d;
    host_wr(0, 12'h100); host_wr(1, 12'h105);
    host_wr(2, 12'hFF0); host_wr(3, 12'h002);
    host_rd(0, d); chk("R8 start1", d, 12'h100);
    host_rd(1, d); chk("R8 end1", d, 12'h105);
    host_rd(2, d); chk("R8 start2", d, 12'hFF0);
    host_rd(3, d); chk("R8 end2", d, 12'h002);
    host_wr(4, 12'hFFF);
    host_rd(4, d); chk("R8 status ro", d, 0);
    host_rd(0, d); chk("R8 status write no side effect", d, 12'h100);
    host_rd(6, d); chk("R8 addr6", d, 0);
    host_rd(5, d); chk("R8 addr5", d, 0);
    hcmd_n = 1; hce_n = 0; hrw = 0; haddr = 0; hwdata = 12'h777;
    tick();
    #1 chk("R8 unselected read", hrdata, 0);
    hce_n = 1; hrw = 1;
    host_rd(0, d); chk("R8 unselected write ignored", d, 12'h100);
  endtask

  task automatic t_strobe();
    strt2_n = 0; tick(); strt2_n = 1;
    chk("R4 strobe2", ptr, 12'hFF0);
    strt1_n = 0; strt2_n = 0; tick(); strt1_n = 1; strt2_n = 1;
    chk("R4 both strobes", ptr, 12'h100);
    chk("R9 legal strobe", proto_err, 0);
  endtask

  task automatic t_inc_flag();
    count(4);
    chk("R2 inc x4", ptr, 12'h104);
    chk("R6 not yet", eob1_n, 1);
    count(1);
    chk("R6 hit end1", eob1_n, 0);
    chk("R6 other flag", eob2_n, 1);
    count(1);
    chk("R2 inc past end", ptr, 12'h106);
    chk("R6 sticky", eob1_n, 0);
  endtask

  task automatic t_clear();
    logic [11:0] d;
    host_rd(4, d); chk("R8 status flag1", d, 12'h001);
    host_wr(5, 12'h002);
    chk("R7 clear flag1", eob1_n, 1);
  endtask

  task automatic t_wrap_and_keep();
    logic [11:0] d;
    strt2_n = 0; tick(); strt2_n = 1;
    count(15); chk("R2 top", ptr, 12'hFFF);
    count(1);  chk("R2 wrap", ptr, 12'h000);
    chk("R6 no flag yet", eob2_n, 1);
    count(2);  chk("R6 after wrap hit end2", eob2_n, 0);
    strt1_n = 0; tick(); strt1_n = 1;
    count(5);
    host_rd(4, d); chk("R8 status both", d, 12'h003);
    host_wr(5, 12'h001);
    chk("R7 bit0 one keeps flag1", eob1_n, 0);
    chk("R7 bit1 zero clears flag2", eob2_n, 1);
    host_wr(5, 12'h000);
    chk("R7 clear both", eob1_n, 1);
  endtask

  task automatic t_no_flag_on_jump();
    host_wr(1, 12'h100);
    strt1_n = 0; tick(); strt1_n = 1;
    chk("R6 strobe onto end", eob1_n, 1);
    host_wr(1, 12'h105);
    sdata = 16'h0105; ld_n = 0; tick(); ld_n = 1; tick();
    chk("R3 load to 0x105", ptr, 12'h105);
    chk("R6 load onto end", eob1_n, 1);
  endtask

  task automatic t_load();
    logic [11:0] p;
    p = ptr;
    sdata = 16'hFABC; ld_n = 0; cnt_en_n = 0; tick();
    chk("R3 capture edge holds", ptr, p);
    ld_n = 1; sdata = 16'h0000; tick();
    chk("R5 load beats inc", ptr, 12'hABC);
    tick(); cnt_en_n = 1;
    chk("R2 inc after load", ptr, 12'hABD);
  endtask

  task automatic t_priority();
    strt1_n = 0; cnt_en_n = 0; tick(); strt1_n = 1; cnt_en_n = 1;
    chk("R5 strobe beats inc", ptr, 12'h100);
  endtask

  task automatic t_proto();
    sdata = 16'h0200; ld_n = 0; strt1_n = 0; tick();
    chk("R9 strobe with load", proto_err, 1);
    chk("R5 capture beats strobe", ptr, 12'h100);
    ld_n = 1; tick();
    chk("R9 strobe in pending cycle", proto_err, 1);
    chk("R5 pending load beats strobe", ptr, 12'h200);
    strt1_n = 1; tick();
    chk("R9 pulse ends", proto_err, 0);
  endtask

  task automatic t_qual();
    sce_n = 0; srw = 0; sdata = 16'h5A5A; cnt_en_n = 0; tick(); cnt_en_n = 1;
    chk("R10 write", mem_wr, 1);
    chk("R10 write no read", mem_rd, 0);
    chk("R10 addr before inc", acc_addr, 12'h200);
    chk("R10 wdata", acc_wdata, 16'h5A5A);
    srw = 1; soe_n = 1; tick();
    chk("R10 write ends, no read w/o oe", {mem_wr, mem_rd}, 0);
    soe_n = 0; tick();
    chk("R10 read", mem_rd, 1);
    chk("R10 read addr", acc_addr, 12'h201);
    sce_n = 1; tick();
    chk("R10 read off", mem_rd, 0);
    soe_n = 1;
  endtask

  task automatic t_async_reset();
    logic [11:0] d;
    strt1_n = 0; tick(); strt1_n = 1;
    count(5);
    chk("R6 set before reset", eob1_n, 0);
    @(negedge clk); #0.5 rst_n = 0; #0.5;
    chk("R1 async ptr", ptr, 0);
    chk("R1 async eob1", eob1_n, 1);
    host_rd(0, d); chk("R1 async regs", d, 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    tick(); tick();
    t_reset();
    t_regs();
    t_strobe();
    t_inc_flag();
    t_clear();
    t_wrap_and_keep();
    t_no_flag_on_jump();
    t_load();
    t_priority();
    t_proto();
    t_qual();
    t_async_reset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule